// File: doc/BRIEF.md
# Configurable UART Character Framer

This block turns parallel bytes into asynchronous serial characters and recovers bytes from a serial line. Its framing comes from two mode registers that share one write/read address. A pointer chooses which register that address reaches. After reset, or after a pointer-home command, the pointer selects mode register 1. Any access to mode register 1 moves the pointer on to mode register 2, and the pointer then stays there until it is sent home again.

Mode register 1 selects the character length, from five to eight data bits. It also selects how the optional extra bit after the data is used: as a computed odd or even parity bit, as a fixed forced value, as an address/data marker for multidrop networks, or not at all. Mode register 2 selects one or two stop bits. Every bit lasts sixteen pulses of a 16x rate enable that comes from an external baud generator. The receiver checks for a start bit at mid-bit, samples each later bit at its centre, and reports parity and framing errors together with each byte it receives.

Top module: `uf_framer`

## Requirements
- R1: One register address reaches mode register 1 after reset or after a `ptr_home` pulse. A write or read in that state moves the pointer to mode register 2. Later accesses stay on mode register 2. `ptr_home` takes priority over an access in the same cycle. `reg_rdata` shows the register the pointer selects.
- R2: A transmitted frame holds each bit for 16 `tick16` pulses and runs in this order: one low start bit, N = 5 + MR1[1:0] data bits sent LSB first, the extra bit when the mode uses one, then one high stop bit (MR2[0]=0) or two (MR2[0]=1). `txd` is high whenever `tx_busy` is low.
- R3: With MR1[4:3]=00 (parity), the extra bit makes the number of ones across the N data bits and the extra bit even when MR1[2]=0 and odd when MR1[2]=1.
- R4: With MR1[4:3]=01 (forced), the transmitted extra bit equals MR1[2]. The receiver raises `rx_par_err` when the received extra bit differs from MR1[2].
- R5: With MR1[4:3]=10 (none), no extra bit is sent or expected, MR1[2] has no effect on the waveform, and `rx_par_err` and `rx_adbit` stay 0.
- R6: With MR1[4:3]=11 (multidrop), the extra bit on the line is `tx_addr` XOR MR1[2]. The receiver reports `rx_adbit` as the line bit XOR MR1[2] and never raises `rx_par_err`.
- R7: With MR1[4:3]=00, a received extra bit that breaks the selected parity raises `rx_par_err` with that character.
- R8: `rx_frm_err` is set with a character whose first stop bit is sampled low. The data bits are still delivered.
- R9: A low pulse on `rxd` that has ended before the mid-start check is rejected as a false start and produces no `rx_valid`.
- R10: `rx_valid` pulses for exactly one cycle per character. `rx_data` holds the N data bits right-aligned with the upper bits zero, and it keeps its value until the next character.
- R11: A `tx_load` pulse while `tx_busy` is high is ignored. The frame in progress is not changed and no second frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register the pointer selects |
| reg_rd | input | 1 | Read access strobe (steps the pointer like a write) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Contents of the register the pointer selects |
| ptr_home | input | 1 | Returns the pointer to mode register 1 |
| tick16 | input | 1 | 16x bit-rate enable |
| tx_load | input | 1 | Starts a frame with `tx_data` when idle |
| tx_data | input | 8 | Byte to send (bits above N ignored) |
| tx_addr | input | 1 | Address marker for multidrop mode |
| tx_busy | output | 1 | Frame in progress |
| txd | output | 1 | Serial transmit line, idles high |
| rxd | input | 1 | Serial receive line |
| rx_valid | output | 1 | One-cycle pulse when a character is complete |
| rx_data | output | 8 | Received byte, right-aligned |
| rx_par_err | output | 1 | Parity or forced-bit mismatch for the last character |
| rx_frm_err | output | 1 | First stop bit sampled low for the last character |
| rx_adbit | output | 1 | Decoded address/data marker (multidrop mode) |

## Verification
The bench sweeps every parity mode, both values of MR1[2], all four lengths and both stop settings. It loops the transmitter back to the receiver and compares the full waveform and the recovered byte with values it computes itself. A framer with the wrong data-bit count, with odd and even parity swapped, or that let MR1[2] change a no-parity frame would put a different bit pattern on the line. A pointer that fails to step, or steps back from mode register 2, would read back the wrong register. The bench also injects frames with a bad parity bit, a bad forced bit, a low stop bit and a short glitch. A receiver that ignored these would miss an error flag or deliver a phantom character. A second load while a frame is running must leave that frame intact, and no extra frame may follow it.

// File: rtl/uf_pkg.sv
// Shared types and helpers for the UART framer.
// Assumes data bytes of at most 8 bits; character length is 5..8.
package uf_pkg;

    typedef enum logic [1:0] {
        PM_WITH  = 2'b00,
        PM_FORCE = 2'b01,
        PM_NONE  = 2'b10,
        PM_MDROP = 2'b11
    } par_mode_t;

    typedef struct packed {
        par_mode_t  pm;
        logic       sel;
        logic [1:0] len;
        logic       two_stop;
    } frame_cfg_t;

    // Number of data bits for a length code.
    function automatic logic [3:0] nbits(input logic [1:0] len);
        return 4'd5 + {2'b00, len};
    endfunction

    // Mask that keeps the active data bits.
    function automatic logic [7:0] dmask(input logic [1:0] len);
        return 8'hFF >> (2'd3 - len);
    endfunction

endpackage

// File: rtl/uf_modereg.sv
// Two mode registers behind one address, selected by a pointer.
// The pointer starts on register 1. Any access to it steps the pointer
// to register 2, where it stays until the home command or reset.
module uf_modereg
    import uf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          rd,
    input  logic [DW-1:0] wdata,
    input  logic          home,
    output logic [DW-1:0] rdata,
    output logic          ptr,
    output frame_cfg_t    cfg
);

    logic [DW-1:0] mr1_q, mr2_q;

    // Pointer and register storage update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr   <= 1'b0;
            mr1_q <= '0;
            mr2_q <= '0;
        end else if (home) begin
            ptr <= 1'b0;
        end else if (wr || rd) begin
            if (!ptr) begin
                if (wr) mr1_q <= wdata;
                ptr <= 1'b1;
            end else if (wr) begin
                mr2_q <= wdata;
            end
        end
    end

    // Read mux and framing fields.
    always_comb begin
        rdata        = ptr ? mr2_q : mr1_q;
        cfg.pm       = par_mode_t'(mr1_q[4:3]);
        cfg.sel      = mr1_q[2];
        cfg.len      = mr1_q[1:0];
        cfg.two_stop = mr2_q[0];
    end

endmodule

// File: rtl/uf_tx.sv
// Transmit framer: start bit, 5..8 data bits LSB first, optional extra
// bit, one or two stop bits, each lasting OVS tick pulses.
// Assumes tick is a single-cycle enable. Framing is latched at load.
module uf_tx
    import uf_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       load,
    input  logic [7:0] data,
    input  logic       addr,
    input  par_mode_t  pm,
    input  logic       sel,
    input  logic [1:0] len,
    input  logic       two_stop,
    output logic       txd,
    output logic       busy
);

    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tst_t;

    tst_t       st;
    logic [CW-1:0] cnt;
    logic [7:0] sh;
    logic [2:0] bidx;
    logic       ebit, ebit_q, sidx, two_q;
    par_mode_t  pm_q;
    logic [1:0] len_q;

    // Extra bit value for the byte being loaded.
    always_comb begin
        case (pm)
            PM_WITH:  ebit = (^(data & dmask(len))) ^ sel;
            PM_FORCE: ebit = sel;
            PM_MDROP: ebit = addr ^ sel;
            default:  ebit = 1'b0;
        endcase
    end

    // Frame sequencer and line driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= T_IDLE;
            cnt    <= '0;
            sh     <= '0;
            bidx   <= '0;
            ebit_q <= 1'b0;
            sidx   <= 1'b0;
            two_q  <= 1'b0;
            pm_q   <= PM_NONE;
            len_q  <= '0;
            txd    <= 1'b1;
        end else if (st == T_IDLE) begin
            if (load) begin
                st     <= T_START;
                cnt    <= '0;
                sh     <= data;
                ebit_q <= ebit;
                pm_q   <= pm;
                len_q  <= len;
                two_q  <= two_stop;
                txd    <= 1'b0;
            end
        end else if (tick) begin
            if (cnt != LAST) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
                case (st)
                    T_START: begin
                        st   <= T_DATA;
                        bidx <= '0;
                        txd  <= sh[0];
                        sh   <= sh >> 1;
                    end
                    T_DATA: begin
                        if ({1'b0, bidx} == nbits(len_q) - 4'd1) begin
                            if (pm_q != PM_NONE) begin
                                st  <= T_PAR;
                                txd <= ebit_q;
                            end else begin
                                st   <= T_STOP;
                                sidx <= 1'b0;
                                txd  <= 1'b1;
                            end
                        end else begin
                            bidx <= bidx + 1'b1;
                            txd  <= sh[0];
                            sh   <= sh >> 1;
                        end
                    end
                    T_PAR: begin
                        st   <= T_STOP;
                        sidx <= 1'b0;
                        txd  <= 1'b1;
                    end
                    T_STOP: begin
                        if (sidx == two_q) st <= T_IDLE;
                        else               sidx <= 1'b1;
                    end
                    default: st <= T_IDLE;
                endcase
            end
        end
    end

    assign busy = (st != T_IDLE);

endmodule

// File: rtl/uf_rx.sv
// Receive framer: synchronises the line, confirms the start bit at
// mid-bit, samples each later bit at its centre and reports errors.
// Assumes the framing fields stay stable during a character.
module uf_rx
    import uf_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  par_mode_t  pm,
    input  logic       sel,
    input  logic [1:0] len,
    output logic       valid,
    output logic [7:0] data,
    output logic       par_err,
    output logic       frm_err,
    output logic       adbit
);

    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);

    typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rst_t;

    rst_t       st;
    logic       s1, s2;
    logic [CW-1:0] cnt;
    logic [7:0] sh;
    logic [2:0] bidx;
    logic       acc, pbit;

    // Two-stage synchroniser on the serial input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= rxd;
            s2 <= s1;
        end
    end

    // Bit sampler and character result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= R_IDLE;
            cnt     <= '0;
            sh      <= '0;
            bidx    <= '0;
            acc     <= 1'b0;
            pbit    <= 1'b0;
            valid   <= 1'b0;
            data    <= '0;
            par_err <= 1'b0;
            frm_err <= 1'b0;
            adbit   <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (tick) begin
                case (st)
                    R_IDLE: begin
                        if (!s2) begin
                            st  <= R_START;
                            cnt <= '0;
                        end
                    end
                    R_START: begin
                        if (cnt != MID) begin
                            cnt <= cnt + 1'b1;
                        end else begin
                            cnt  <= '0;
                            bidx <= '0;
                            acc  <= 1'b0;
                            st   <= s2 ? R_IDLE : R_DATA;
                        end
                    end
                    R_DATA: begin
                        if (cnt != LAST) begin
                            cnt <= cnt + 1'b1;
                        end else begin
                            cnt  <= '0;
                            sh   <= {s2, sh[7:1]};
                            acc  <= acc ^ s2;
                            bidx <= bidx + 1'b1;
                            if ({1'b0, bidx} == nbits(len) - 4'd1)
                                st <= (pm != PM_NONE) ? R_PAR : R_STOP;
                        end
                    end
                    R_PAR: begin
                        if (cnt != LAST) begin
                            cnt <= cnt + 1'b1;
                        end else begin
                            cnt  <= '0;
                            pbit <= s2;
                            st   <= R_STOP;
                        end
                    end
                    R_STOP: begin
                        if (cnt != LAST) begin
                            cnt <= cnt + 1'b1;
                        end else begin
                            cnt     <= '0;
                            st      <= R_IDLE;
                            valid   <= 1'b1;
                            data    <= sh >> (4'd8 - nbits(len));
                            frm_err <= ~s2;
                            case (pm)
                                PM_WITH:  par_err <= pbit ^ acc ^ sel;
                                PM_FORCE: par_err <= pbit ^ sel;
                                default:  par_err <= 1'b0;
                            endcase
                            adbit <= (pm == PM_MDROP) ? (pbit ^ sel) : 1'b0;
                        end
                    end
                    default: st <= R_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/uf_framer.sv
// Top of the UART character framer: mode registers, transmit framer and
// receive framer. Assumes tick16 comes from an external rate generator.
module uf_framer
    import uf_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ptr_home,
    input  logic       tick16,
    input  logic       tx_load,
    input  logic [7:0] tx_data,
    input  logic       tx_addr,
    output logic       tx_busy,
    output logic       txd,
    input  logic       rxd,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_par_err,
    output logic       rx_frm_err,
    output logic       rx_adbit
);

    frame_cfg_t cfg;
    logic       mr_ptr;

    uf_modereg #(.DW(8)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .rd    (reg_rd),
        .wdata (reg_wdata),
        .home  (ptr_home),
        .rdata (reg_rdata),
        .ptr   (mr_ptr),
        .cfg   (cfg)
    );

    uf_tx #(.OVS(OVS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .load     (tx_load),
        .data     (tx_data),
        .addr     (tx_addr),
        .pm       (cfg.pm),
        .sel      (cfg.sel),
        .len      (cfg.len),
        .two_stop (cfg.two_stop),
        .txd      (txd),
        .busy     (tx_busy)
    );

    uf_rx #(.OVS(OVS)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .rxd     (rxd),
        .pm      (cfg.pm),
        .sel     (cfg.sel),
        .len     (cfg.len),
        .valid   (rx_valid),
        .data    (rx_data),
        .par_err (rx_par_err),
        .frm_err (rx_frm_err),
        .adbit   (rx_adbit)
    );

endmodule

// File: rtl/uf_chk.sv
// Protocol checks for uf_framer, attached with bind.
module uf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic       ptr_home,
    input logic       mr_ptr,
    input logic       tx_load,
    input logic       tx_busy,
    input logic       txd,
    input logic       rx_valid,
    input logic       rx_par_err,
    input logic [1:0] pm
);

    // R1
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_home && (reg_wr || reg_rd) && !mr_ptr) |=> mr_ptr);

    // R1
    ptr_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_home |=> !mr_ptr);

    // R1
    ptr_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_home && mr_ptr) |=> mr_ptr);

    // R2
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !txd);

    // R11
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(tx_load));

    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5
    quiet_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && $past(pm[1])) |-> !rx_par_err);

endmodule

bind uf_framer uf_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .ptr_home   (ptr_home),
    .mr_ptr     (mr_ptr),
    .tx_load    (tx_load),
    .tx_busy    (tx_busy),
    .txd        (txd),
    .rx_valid   (rx_valid),
    .rx_par_err (rx_par_err),
    .pm         (cfg.pm)
);

// File: tb/sim_uf_framer.sv
// Self-checking bench: sweeps framing configurations in loopback, then
// injects faulty frames on the receive line.
module sim_uf_framer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, ptr_home = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tick16 = 1'b1;
    logic       tx_load = 1'b0, tx_addr = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_busy, txd;
    logic       rxd, rxd_drv = 1'b1, loop = 1'b0;
    logic       rx_valid, rx_par_err, rx_frm_err, rx_adbit;
    logic [7:0] rx_data;

    int n_vec = 0, n_bad = 0, rx_cnt = 0, cyc = 0;

    assign rxd = loop ? txd : rxd_drv;

    always #10 clk = ~clk;

    uf_framer u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ptr_home(ptr_home),
        .tick16(tick16), .tx_load(tx_load), .tx_data(tx_data),
        .tx_addr(tx_addr), .tx_busy(tx_busy), .txd(txd), .rxd(rxd),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_adbit(rx_adbit)
    );

    // Count received characters and watch for a hung run.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rx_valid) rx_cnt <= rx_cnt + 1;
        if (cyc > 190000) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp<190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk); reg_rd = 1'b1; v = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic home();
        @(negedge clk); ptr_home = 1'b1;
        @(negedge clk); ptr_home = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] pm, input logic sel,
                            input logic [1:0] len, input logic two);
        home();
        wr({3'b000, pm, sel, len});
        wr({7'b0, two});
    endtask

    // Send one byte, compare the line waveform bit by bit and the loopback result.
    task automatic send_chk(input logic [1:0] pm, input logic sel,
                            input logic [1:0] len, input logic two,
                            input logic [7:0] d, input logic a,
                            input bit poke, input string req);
        int n, t, rc0;
        logic [11:0] expv, obs;
        logic eb;
        logic [7:0] m;
        n = 5 + int'(len);
        m = 8'hFF >> (3 - int'(len));
        case (pm)
            2'b00:   eb = (^(d & m)) ^ sel;
            2'b01:   eb = sel;
            2'b11:   eb = a ^ sel;
            default: eb = 1'b0;
        endcase
        expv = '1;
        expv[0] = 1'b0;
        for (int i = 0; i < n; i++) expv[1 + i] = d[i];
        if (pm != 2'b10) expv[1 + n] = eb;
        t = 1 + n + ((pm != 2'b10) ? 1 : 0) + (two ? 2 : 1);
        obs = '1;
        rc0 = rx_cnt;
        @(negedge clk); tx_load = 1'b1; tx_data = d; tx_addr = a;
        @(posedge clk);
        @(negedge clk); tx_load = 1'b0;
        repeat (8) @(negedge clk);
        for (int j = 0; j < t; j++) begin
            obs[j] = txd;
            if (j == t - 1) break;
            if (poke && j == 3) begin
                tx_load = 1'b1; tx_data = ~d;
                @(negedge clk); tx_load = 1'b0;
                repeat (15) @(negedge clk);
            end else begin
                repeat (16) @(negedge clk);
            end
        end
        repeat (9) @(negedge clk);
        chk(obs == expv, req, "tx waveform", {20'b0, obs}, {20'b0, expv});
        chk(!tx_busy && txd, "R11", "idle after frame", {30'b0, tx_busy, txd}, 32'h1);
        if (loop) begin
            chk(rx_cnt == rc0 + 1, "R10", "one rx_valid", rx_cnt, rc0 + 1);
            chk({rx_data, rx_par_err, rx_frm_err, rx_adbit} ==
                {d & m, 1'b0, 1'b0, (pm == 2'b11) ? a : 1'b0},
                req, "rx result",
                {21'b0, rx_data, rx_par_err, rx_frm_err, rx_adbit},
                {21'b0, d & m, 2'b00, (pm == 2'b11) ? a : 1'b0});
        end
    endtask

    // Drive an 8-bit frame with chosen extra and stop bits on rxd.
    task automatic drive8(input logic [7:0] d, input logic eb, input logic sb);
        logic [10:0] v;
        v = {sb, eb, d, 1'b0};
        for (int j = 0; j < 11; j++) begin
            @(negedge clk); rxd_drv = v[j];
            repeat (15) @(negedge clk);
        end
        @(negedge clk); rxd_drv = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] pat [5];
        int rc0;
        pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'hA5; pat[3] = 8'h5A; pat[4] = 8'h13;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd && !tx_busy && !rx_valid && reg_rdata == 8'h00, "R2", "reset state",
            {29'b0, txd, tx_busy, rx_valid}, 32'h4);

        // R1 pointer stepping
        wr(8'h1B);
        wr(8'h40);
        wr(8'h41);
        rd(v); chk(v == 8'h41, "R1", "pointer stays on MR2", {24'b0, v}, 32'h41);
        home();
        rd(v); chk(v == 8'h1B, "R1", "home reaches MR1", {24'b0, v}, 32'h1B);
        rd(v); chk(v == 8'h41, "R1", "read steps to MR2", {24'b0, v}, 32'h41);
        @(negedge clk); ptr_home = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h77;
        @(negedge clk); ptr_home = 1'b0; reg_wr = 1'b0;
        rd(v); chk(v == 8'h1B, "R1", "home wins over write", {24'b0, v}, 32'h1B);

        // Loopback sweep over every framing setting
        loop = 1'b1;
        for (int pm = 0; pm < 4; pm++)
            for (int s = 0; s < 2; s++)
                for (int l = 0; l < 4; l++)
                    for (int two = 0; two < 2; two++) begin
                        set_mode(2'(pm), 1'(s), 2'(l), 1'(two));
                        for (int k = 0; k < 5; k++)
                            send_chk(2'(pm), 1'(s), 2'(l), 1'(two), pat[k], 1'(k),
                                     1'b0, pm == 0 ? "R3" : pm == 1 ? "R4" :
                                     pm == 2 ? "R5" : "R6");
                    end

        // R11 load while busy is ignored
        set_mode(2'b00, 1'b0, 2'b11, 1'b0);
        send_chk(2'b00, 1'b0, 2'b11, 1'b0, 8'hC3, 1'b0, 1'b1, "R11");

        // Receive-side fault injection
        loop = 1'b0;
        rc0 = rx_cnt;
        drive8(8'h35, 1'b1, 1'b1);
        chk(rx_par_err == 1'b1 && rx_data == 8'h35, "R7", "bad even parity",
            {23'b0, rx_par_err, rx_data}, 32'h135);
        drive8(8'h35, 1'b0, 1'b1);
        chk(rx_par_err == 1'b0, "R7", "good even parity", {31'b0, rx_par_err}, 0);
        set_mode(2'b01, 1'b1, 2'b11, 1'b0);
        drive8(8'h96, 1'b0, 1'b1);
        chk(rx_par_err == 1'b1, "R4", "forced bit mismatch", {31'b0, rx_par_err}, 1);
        drive8(8'h96, 1'b1, 1'b1);
        chk(rx_par_err == 1'b0, "R4", "forced bit match", {31'b0, rx_par_err}, 0);
        set_mode(2'b11, 1'b1, 2'b11, 1'b0);
        drive8(8'h42, 1'b0, 1'b1);
        chk(rx_adbit == 1'b1 && rx_par_err == 1'b0, "R6", "multidrop marker",
            {30'b0, rx_adbit, rx_par_err}, 32'h2);
        set_mode(2'b00, 1'b0, 2'b11, 1'b0);
        drive8(8'h81, 1'b0, 1'b0);
        chk(rx_frm_err == 1'b1 && rx_data == 8'h81, "R8", "low stop bit",
            {23'b0, rx_frm_err, rx_data}, 32'h181);
        chk(rx_cnt == rc0 + 6, "R10", "one pulse per frame", rx_cnt, rc0 + 6);
        drive8(8'h81, 1'b0, 1'b1);
        chk(rx_frm_err == 1'b0, "R8", "good stop bit", {31'b0, rx_frm_err}, 0);

        // R9 false start glitch
        rc0 = rx_cnt;
        @(negedge clk); rxd_drv = 1'b0;
        repeat (5) @(negedge clk); rxd_drv = 1'b1;
        repeat (300) @(negedge clk);
        chk(rx_cnt == rc0, "R9", "glitch rejected", rx_cnt, rc0);
        drive8(8'h5C, 1'b0, 1'b1);
        chk(rx_cnt == rc0 + 1 && rx_data == 8'h5C, "R9", "frame after glitch",
            {16'b0, 8'(rx_cnt - rc0), rx_data}, 32'h015C);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule